// File: doc/BRIEF.md
# Bus Wait-State Generator with Ready Extension

This block lengthens external read and write bus cycles. A cycle opens on a read or write start strobe. The block then holds a stall output high toward the bus sequencer until the cycle may close. When the cycle closes, it drops stall and pulses a cycle-done output for one clock. Timing is counted in falling edges of the bus clock. Inside the single synchronous clock domain, each falling edge is represented by a one-clock `bus_fall` strobe, and the active-low ready input is only examined on those strobes.

A two-bit mode field and a two-bit wait-length field are captured when a cycle starts. The extended mode (code 11) adds a programmed wait period of 1 to 3 bus clocks after the base cycle. At the last falling edge of each wait period, the ready input is examined. A low level adds another whole period. A high level releases the cycle once that period is over. Every other mode code passes the cycle through with no added wait.

Top module: `bus_wait_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `stall` and `cyc_done` are 0 after that edge, and the block returns to idle, including from the middle of a cycle.
- R2: In idle, a high `cyc_rd_start` or `cyc_wr_start` (or both) at a clock edge raises `stall` after that edge. Read and write cycles have identical timing.
- R3: For a captured mode code other than binary 11, `stall` falls at the edge of the first `bus_fall` strobe after the start edge.
- R4: For mode 11, a wait period of n bus falls follows the base fall. Wait-length code 01 gives n=1, 10 gives n=2, 11 gives n=3, and 00 is treated as n=1.
- R5: If `rdy_n` is 0 on the `bus_fall` that closes a wait period, a further full period of n falls is added.
- R6: If `rdy_n` is 1 on the closing fall of a period, `stall` falls at that edge. A high `rdy_n` on a fall inside a period does not shorten that period.
- R7: `cyc_done` is high for exactly one clock, on the same clock in which `stall` first reads 0 after a cycle.
- R8: A start strobe that arrives while a cycle is active is ignored and does not change that cycle's release point.
- R9: `cfg_mode` and `cfg_wlen` are captured at the start edge. Changes to them during an active cycle do not affect that cycle.
- R10: While a cycle is active, `stall` can only fall at an edge where `bus_fall` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_fall | input | 1 | One-clock strobe marking a falling edge of the bus clock |
| cyc_rd_start | input | 1 | Opens a read cycle |
| cyc_wr_start | input | 1 | Opens a write cycle |
| cfg_mode | input | 2 | Wait mode select, 11 = fixed wait plus ready extension |
| cfg_wlen | input | 2 | Wait period length in bus clocks (00 treated as 1) |
| rdy_n | input | 1 | External ready, active low |
| stall | output | 1 | High while the current bus cycle is held |
| cyc_done | output | 1 | One-clock pulse when a cycle completes |

## Verification
The hardest cases to reach from the ports involve ready changing inside a wait period. In one case ready is high on an inner fall but low again on the closing fall. In the other, the configuration is rewritten and a second start strobe arrives while a long cycle is still held. The bench drives `rdy_n` as a function of the bus-fall index counted from the start. It can therefore place a low level on exactly the closing fall of the first period while keeping it high elsewhere. Every run also rewrites the configuration and injects a start strobe in its third clock. The release fall index is computed arithmetically from the mode, the period length and the ready pattern, and is compared with the fall on which `stall` drops.

// File: rtl/bwg_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, state encoding and configuration record for the
// bus wait-state generator. Assumes two-bit mode and wait-length fields.
package bwg_pkg;
    localparam int MODE_W = 2;
    localparam int WLEN_W = 2;
    localparam int CNT_W  = WLEN_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_WAIT = 2'd2
    } bwg_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [WLEN_W-1:0] wlen;
    } bwg_cfg_t;
endpackage

// File: rtl/bwg_cfg_latch.sv
`timescale 1ns/1ps
// Configuration latch: captures mode and wait length when a cycle opens and
// holds them for the whole cycle. Decodes the extended-mode flag and the
// effective period length (a zero length code is treated as one).
// Assumes capture is only raised in idle.
module bwg_cfg_latch
    import bwg_pkg::*;
#(
    parameter logic [MODE_W-1:0] EXT_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  bwg_cfg_t         cfg_in,
    output logic             ext_mode,
    output logic [CNT_W-1:0] period_len
);
    bwg_cfg_t cfg_q;

    // Hold the configuration seen at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
        end
    end

    // Decode the held configuration.
    always_comb begin
        ext_mode   = (cfg_q.mode == EXT_CODE);
        period_len = (cfg_q.wlen == '0) ? CNT_W'(1) : CNT_W'(cfg_q.wlen);
    end
endmodule

// File: rtl/bwg_period_ctr.sv
`timescale 1ns/1ps
// Wait period counter: counts bus falls remaining in the current wait
// period and flags the fall that closes it. Assumes load and active come
// from the control FSM. A load takes priority over counting.
module bwg_period_ctr
    import bwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             tick,
    input  logic             active,
    output logic             period_end
);
    logic [CNT_W-1:0] remain_q;

    // Reload on period entry, count down on each bus fall otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= len;
        end else if (tick && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // The closing fall of a period is the one seen with one fall left.
    assign period_end = active && tick && (remain_q == CNT_W'(1));
endmodule

// File: rtl/bwg_ctrl.sv
`timescale 1ns/1ps
// Control FSM: opens a cycle on a start strobe and holds it through the base
// fall. In extended mode it then runs wait periods, adding one more each
// time ready is low on a closing fall. Drives registered stall and done.
// Assumes ext_mode is stable from the edge after capture.
module bwg_ctrl
    import bwg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic bus_fall,
    input  logic rdy_n,
    input  logic ext_mode,
    input  logic period_end,
    output logic capture,
    output logic load,
    output logic in_wait,
    output logic stall,
    output logic done
);
    bwg_state_e state_q;

    // Derive the strobes seen by the latch and the counter.
    always_comb begin
        capture = (state_q == ST_IDLE) && start_req;
        in_wait = (state_q == ST_WAIT);
        load    = ((state_q == ST_BASE) && bus_fall && ext_mode) ||
                  (period_end && !rdy_n);
    end

    // Advance the cycle state and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stall   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q <= ST_BASE;
                        stall   <= 1'b1;
                    end
                end
                ST_BASE: begin
                    if (bus_fall) begin
                        if (ext_mode) begin
                            state_q <= ST_WAIT;
                        end else begin
                            state_q <= ST_IDLE;
                            stall   <= 1'b0;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (period_end && rdy_n) begin
                        state_q <= ST_IDLE;
                        stall   <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    stall   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/bus_wait_gen.sv
`timescale 1ns/1ps
// Top: bus wait-state generator with ready extension. Bus clock falling
// edges arrive as the bus_fall strobe in the clk domain. Assumes rdy_n is
// already synchronised to clk.
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter logic [MODE_W-1:0] EXT_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_fall,
    input  logic              cyc_rd_start,
    input  logic              cyc_wr_start,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [WLEN_W-1:0] cfg_wlen,
    input  logic              rdy_n,
    output logic              stall,
    output logic              cyc_done
);
    logic             start_req;
    logic             capture;
    logic             load;
    logic             in_wait;
    logic             ext_mode;
    logic             period_end;
    logic [CNT_W-1:0] period_len;
    bwg_cfg_t         cfg_in;

    // Reads and writes share one timing path.
    always_comb begin
        start_req   = cyc_rd_start | cyc_wr_start;
        cfg_in.mode = cfg_mode;
        cfg_in.wlen = cfg_wlen;
    end

    bwg_cfg_latch #(.EXT_CODE(EXT_CODE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cfg_in     (cfg_in),
        .ext_mode   (ext_mode),
        .period_len (period_len)
    );

    bwg_period_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .len        (period_len),
        .tick       (bus_fall),
        .active     (in_wait),
        .period_end (period_end)
    );

    bwg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .bus_fall   (bus_fall),
        .rdy_n      (rdy_n),
        .ext_mode   (ext_mode),
        .period_end (period_end),
        .capture    (capture),
        .load       (load),
        .in_wait    (in_wait),
        .stall      (stall),
        .done       (cyc_done)
    );
endmodule

// File: rtl/bus_wait_gen_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the wait-state generator, bound to the top.
module bus_wait_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_fall,
    input logic cyc_rd_start,
    input logic cyc_wr_start,
    input logic rdy_n,
    input logic stall,
    input logic cyc_done,
    input logic period_end
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!stall && !cyc_done));

    // R2
    stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(cyc_rd_start || cyc_wr_start));

    // R5
    extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !rdy_n) |=> stall);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && rdy_n) |=> (!stall && cyc_done));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // R7
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (!stall && $past(stall)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bus_fall) |=> stall);
endmodule

bind bus_wait_gen bus_wait_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_fall     (bus_fall),
    .cyc_rd_start (cyc_rd_start),
    .cyc_wr_start (cyc_wr_start),
    .rdy_n        (rdy_n),
    .stall        (stall),
    .cyc_done     (cyc_done),
    .period_end   (period_end)
);

// File: tb/bus_wait_gen_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every mode, wait length, ready pattern and strobe spacing,
// and compares the release fall with an arithmetic prediction.
module bus_wait_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_fall = 1'b0;
    logic       cyc_rd_start = 1'b0;
    logic       cyc_wr_start = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] cfg_wlen = 2'b00;
    logic       rdy_n = 1'b1;
    logic       stall;
    logic       cyc_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_wait_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_fall     (bus_fall),
        .cyc_rd_start (cyc_rd_start),
        .cyc_wr_start (cyc_wr_start),
        .cfg_mode     (cfg_mode),
        .cfg_wlen     (cfg_wlen),
        .rdy_n        (rdy_n),
        .stall        (stall),
        .cyc_done     (cyc_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Ready is low on falls 1..low_n and on the single fall extra_f.
    function automatic bit rdy_low(input int f, input int low_n, input int extra_f);
        return (f <= low_n) || (f == extra_f);
    endfunction

    // Fall index at which the cycle must release.
    function automatic int exp_release(input int mode, input int wl, input int low_n,
                                       input int extra_f);
        int n;
        if (mode != 3) return 1;
        n = (wl == 0) ? 1 : wl;
        for (int j = 1; j < 64; j++) begin
            if (!rdy_low(1 + j * n, low_n, extra_f)) return 1 + j * n;
        end
        return -1;
    endfunction

    task automatic run_cycle(input int mode, input int wl, input int low_n,
                             input int extra_f, input int spacing, input bit wr);
        int rel;
        int fallcnt;
        int ph;
        bit seen;
        bit fell_now;
        rel = exp_release(mode, wl, low_n, extra_f);
        cfg_mode = 2'(mode);
        cfg_wlen = 2'(wl);
        cyc_rd_start = !wr;
        cyc_wr_start = wr;
        bus_fall = 1'b0;
        @(negedge clk);
        // R2: stall rises the clock after the start strobe
        chk(stall === 1'b1, "R2 stall after start", int'(stall), 1);
        cyc_rd_start = 1'b0;
        cyc_wr_start = 1'b0;
        fallcnt = 0;
        ph = 0;
        seen = 1'b0;
        for (int it = 0; it < 200 && !seen; it++) begin
            fell_now = (ph == spacing - 1);
            bus_fall = fell_now;
            ph = fell_now ? 0 : ph + 1;
            rdy_n = !rdy_low(fallcnt + 1, low_n, extra_f);
            if (it == 2) begin
                // R8 / R9: a start and a config rewrite while active
                cfg_mode = ~2'(mode);
                cfg_wlen = 2'(wl + 1);
                cyc_wr_start = 1'b1;
            end else begin
                cyc_wr_start = 1'b0;
            end
            @(negedge clk);
            if (fell_now) fallcnt++;
            if (stall !== 1'b1) begin
                seen = 1'b1;
                // R3 R4 R5 R6 R8 R9: release fall index
                chk(fallcnt == rel, (mode == 3) ? "R4 R5 R6 R9 release fall" : "R3 release fall",
                    fallcnt, rel);
                // R10: drop only on a bus_fall edge
                chk(fell_now, "R10 drop on bus fall", int'(fell_now), 1);
                // R7: done with the drop
                chk(cyc_done === 1'b1, "R7 done at release", int'(cyc_done), 1);
            end else if (cyc_done !== 1'b0) begin
                chk(1'b0, "R7 done while stalled", int'(cyc_done), 0);
            end
        end
        if (!seen) chk(1'b0, "R6 no release", fallcnt, rel);
        bus_fall = 1'b0;
        cyc_wr_start = 1'b0;
        rdy_n = 1'b1;
        @(negedge clk);
        // R7 R8: single pulse, and the ignored start opened nothing
        chk(cyc_done === 1'b0, "R7 done single clock", int'(cyc_done), 0);
        chk(stall === 1'b0, "R8 idle after release", int'(stall), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(stall === 1'b0, "R1 reset stall", int'(stall), 0);
        chk(cyc_done === 1'b0, "R1 reset done", int'(cyc_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int sp = 2; sp <= 3; sp++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 4; w++)
                    for (int l = 0; l < 6; l++)
                        for (int g = 0; g < 2; g++) begin
                            int nn;
                            nn = (w == 0) ? 1 : w;
                            run_cycle(m, w, l, g ? 1 + nn : -1, sp, 1'((m + w + l + g) % 2));
                        end
        // R1: reset in the middle of a long cycle
        cfg_mode = 2'b11;
        cfg_wlen = 2'b11;
        cyc_rd_start = 1'b1;
        rdy_n = 1'b0;
        @(negedge clk);
        cyc_rd_start = 1'b0;
        bus_fall = 1'b1;
        @(negedge clk);
        bus_fall = 1'b0;
        chk(stall === 1'b1, "R2 stall before reset", int'(stall), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(stall === 1'b0, "R1 mid-cycle reset stall", int'(stall), 0);
        chk(cyc_done === 1'b0, "R1 mid-cycle reset done", int'(cyc_done), 0);
        rst_n = 1'b1;
        rdy_n = 1'b1;
        @(negedge clk);
        chk(stall === 1'b0, "R1 idle after reset", int'(stall), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule